// File: doc/BRIEF.md
# Binary Trie Longest-Prefix Lookup Engine

This block resolves a 32-bit destination address to an output port by walking a binary trie stored in an internal node memory. The walk tests one address bit per node, beginning with the most significant bit. A 0 bit selects the left child and a 1 bit selects the right child. Along the way the engine remembers the deepest node that carries a prefix. When the needed child is absent, or when every address bit has been consumed, the engine reports that node's port. If no prefix-bearing node was passed, it raises a miss flag instead.

A control agent fills the node memory through a single-cycle write port. Lookups are accepted with a valid/ready handshake. Each lookup ends with a one-cycle done pulse that carries the port and the miss flag. The engine reads one node per clock from a memory with one cycle of read latency, so a lookup takes at most 33 node reads.

Top module: `trie_lpm`

## Requirements
- R1: After reset, `in_ready` is 1 and `done` is 0.
- R2: A node word written with `wr_en` at `wr_ptr` is laid out as: bits [3:0] the port, bit 4 prefix-valid, bit 5 right-child-valid, bit 6 left-child-valid, bits [12:7] the right-child index, and bits [18:13] the left-child index. The root is always node 0.
- R3: Address bits are consumed from bit 31 downward. A 0 bit follows the left child and a 1 bit follows the right child.
- R4: If a lookup is accepted at clock edge E0 and its walk ends at a node of depth D (the root has depth 0), then `done` is high in the cycle after edge E0+D+1 and low in every cycle before it.
- R5: The walk ends at the first node whose child for the next address bit is not marked valid.
- R6: On `done` with `miss` low, `hit_port` is the port of the deepest prefix-valid node on the path. A shorter enclosing prefix therefore loses to a longer one.
- R7: When no node on the path is prefix-valid, `miss` is 1 on `done`.
- R8: From acceptance until `done`, `in_ready` is 0, and `in_valid` together with `in_addr` has no effect on the result in progress.
- R9: `done` is high for exactly one cycle per lookup.
- R10: A walk that reaches depth 32 ends there, so a 32-bit host prefix can be matched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Lookup request valid |
| in_ready | output | 1 | Engine idle, can accept a lookup |
| in_addr | input | 32 | Destination address |
| wr_en | input | 1 | Node memory write strobe |
| wr_ptr | input | 6 | Node index to write |
| wr_node | input | 19 | Node word to write |
| done | output | 1 | One-cycle result pulse |
| hit_port | output | 4 | Port of the longest matching prefix |
| miss | output | 1 | No prefix matched |

## Verification
The bench builds the engine with its default parameters: 32 address bits, a 64-node memory and 4-bit ports. This is enough to hold a full-length host route next to a nested /8, /16 and /18 family and a /1 route. Walk depths from 1 to 32 are therefore all reachable, including the case that reads 33 nodes. The bench model computes the expected port, miss flag and done cycle from its own route list, never from the trie. Lookups cover nested prefixes, near-misses of the host route, an early dead end with no prefix, and requests driven while the engine is busy.

// File: rtl/trie_lpm.sv
module trie_lpm #(
  parameter int ADDR_W = 32,
  parameter int PTR_W  = 6,
  parameter int PORT_W = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [ADDR_W-1:0]            in_addr,
  input  logic                         wr_en,
  input  logic [PTR_W-1:0]             wr_ptr,
  input  logic [2*PTR_W+3+PORT_W-1:0]  wr_node,
  output logic                         done,
  output logic [PORT_W-1:0]            hit_port,
  output logic                         miss
);
  localparam int NODE_W = 2*PTR_W + 3 + PORT_W;
  localparam int DEPTH  = 1 << PTR_W;
  localparam int DW     = $clog2(ADDR_W + 1);

  logic [NODE_W-1:0] mem [DEPTH];
  logic [NODE_W-1:0] node_q;
  logic [ADDR_W-1:0] key_q;
  logic [DW-1:0]     depth_q;
  logic              busy_q, best_v_q;
  logic [PORT_W-1:0] best_port_q;

  wire [PORT_W-1:0] n_port = node_q[PORT_W-1:0];
  wire              n_pv   = node_q[PORT_W];
  wire              n_rv   = node_q[PORT_W+1];
  wire              n_lv   = node_q[PORT_W+2];
  wire [PTR_W-1:0]  n_rptr = node_q[PORT_W+3 +: PTR_W];
  wire [PTR_W-1:0]  n_lptr = node_q[PORT_W+3+PTR_W +: PTR_W];

  wire              go_right  = key_q[ADDR_W-1];
  wire              child_ok  = go_right ? n_rv : n_lv;
  wire [PTR_W-1:0]  child_ptr = go_right ? n_rptr : n_lptr;
  wire              at_end    = (depth_q == DW'(ADDR_W));
  wire              stop      = busy_q && (at_end || !child_ok);
  wire              accept    = in_valid && !busy_q;
  wire              best_v_n  = best_v_q | n_pv;
  wire [PORT_W-1:0] best_p_n  = n_pv ? n_port : best_port_q;
  wire [PTR_W-1:0]  rd_ptr    = accept ? '0 : child_ptr;

  assign in_ready = !busy_q;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_node;
    node_q <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      done        <= 1'b0;
      miss        <= 1'b0;
      hit_port    <= '0;
      best_v_q    <= 1'b0;
      best_port_q <= '0;
      depth_q     <= '0;
      key_q       <= '0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy_q   <= 1'b1;
        key_q    <= in_addr;
        depth_q  <= '0;
        best_v_q <= 1'b0;
      end else if (busy_q) begin
        if (stop) begin
          busy_q   <= 1'b0;
          done     <= 1'b1;
          miss     <= !best_v_n;
          hit_port <= best_p_n;
        end else begin
          best_v_q    <= best_v_n;
          best_port_q <= best_p_n;
          depth_q     <= depth_q + 1'b1;
          key_q       <= key_q << 1;
        end
      end
    end
  end

  p_ready_low_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  p_no_done_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !done);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> in_ready);
  p_depth_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (depth_q <= DW'(ADDR_W)));
endmodule

// File: tb/trie_lpm_tb.sv
module trie_lpm_tb_top;
  logic clk = 0, rst_n = 0, in_valid = 0, wr_en = 0;
  logic [31:0] in_addr = '0;
  logic [5:0]  wr_ptr = '0;
  logic [18:0] wr_node = '0;
  logic in_ready, done, miss;
  logic [3:0] hit_port;
  int n_cmp = 0, n_bad = 0;

  trie_lpm dut_i (.clk, .rst_n, .in_valid, .in_ready, .in_addr, .wr_en, .wr_ptr,
                  .wr_node, .done, .hit_port, .miss);

  always #5 clk = ~clk;

  // bench-side route list and trie image
  logic [31:0] r_pfx [8];
  int          r_len [8];
  int          r_port[8];
  int          n_routes = 0;
  int bl[64], br[64], blv[64], brv[64], bpv[64], bport[64];
  int nalloc = 1;

  task automatic chk(input bit cond, input string req, input int act, input int exp);
    n_cmp++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic add_route(input logic [31:0] p, input int len, input int port);
    int cur = 0;
    r_pfx[n_routes] = p; r_len[n_routes] = len; r_port[n_routes] = port; n_routes++;
    for (int d = 0; d < len; d++) begin
      if (p[31-d]) begin
        if (!brv[cur]) begin brv[cur] = 1; br[cur] = nalloc; nalloc++; end
        cur = br[cur];
      end else begin
        if (!blv[cur]) begin blv[cur] = 1; bl[cur] = nalloc; nalloc++; end
        cur = bl[cur];
      end
    end
    bpv[cur] = 1; bport[cur] = port;
  endtask

  function automatic int lcp(input logic [31:0] a, input logic [31:0] b);
    for (int i = 0; i < 32; i++) if (a[31-i] != b[31-i]) return i;
    return 32;
  endfunction

  task automatic lookup(input logic [31:0] key, input bit intrude, input string tag);
    int dmax = 0, blen = -1, bp = 0, m;
    for (int i = 0; i < n_routes; i++) begin
      m = lcp(key, r_pfx[i]);
      if ((m < r_len[i] ? m : r_len[i]) > dmax) dmax = (m < r_len[i] ? m : r_len[i]);
      if (m >= r_len[i] && r_len[i] > blen) begin blen = r_len[i]; bp = r_port[i]; end
    end
    @(negedge clk);
    chk(in_ready, "R8", in_ready, 1);
    in_addr = key; in_valid = 1;
    @(negedge clk);
    in_valid = intrude; in_addr = ~key;
    for (int c = 1; c <= dmax + 2; c++) begin
      if (c > 1) @(negedge clk);
      chk(done == (c == dmax + 2), {"R4 ", tag}, done, c == dmax + 2);
      chk(in_ready == (c == dmax + 2), {"R8 ", tag}, in_ready, c == dmax + 2);
      if (c == dmax + 2) begin
        chk(miss == (blen < 0), {"R7 ", tag}, miss, blen < 0);
        if (blen >= 0) chk(hit_port == bp, {"R6 ", tag}, hit_port, bp);
      end
      if (c == dmax + 1) in_valid = 0;
    end
    @(negedge clk);
    chk(!done, {"R9 ", tag}, done, 0);
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) begin
      bl[i] = 0; br[i] = 0; blv[i] = 0; brv[i] = 0; bpv[i] = 0; bport[i] = 0;
    end
    add_route(32'h8000_0000, 8, 5);   // 128/8
    add_route(32'h8020_0000, 16, 1);  // 128.32/16
    add_route(32'h8020_C000, 18, 3);  // 128.32.192/18
    add_route(32'h0000_0000, 1, 2);   // 0/1
    add_route(32'h0A01_0203, 32, 7);  // host route
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b1, "R1", in_ready, 1);
    chk(done === 1'b0, "R1", done, 0);
    rst_n = 1;
    // R2: load node words through the write port
    for (int i = 0; i < nalloc; i++) begin
      @(negedge clk);
      wr_en = 1; wr_ptr = 6'(i);
      wr_node = {6'(bl[i]), 6'(br[i]), 1'(blv[i]), 1'(brv[i]), 1'(bpv[i]), 4'(bport[i])};
    end
    @(negedge clk); wr_en = 0;
    lookup(32'h8020_C301, 0, "R3 nested /18");
    lookup(32'h8020_0101, 0, "R6 /16");
    lookup(32'h80FF_0000, 0, "R6 /8");
    lookup(32'hC000_0001, 0, "R5 dead end miss");
    lookup(32'hFFFF_FFFF, 0, "R7 miss");
    lookup(32'h0A01_0203, 0, "R10 host");
    lookup(32'h0A01_0202, 0, "R10 near host");
    lookup(32'h0000_0001, 0, "R3 /1");
    lookup(32'h8020_C301, 1, "R8 intrude");
    lookup(32'h0A01_0203, 1, "R8 intrude host");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule